// File: doc/BRIEF.md
# One-Time-Programmable Fuse Operation Controller

This block runs one operation at a time on a one-time-programmable fuse bank. Software first loads a target location and a program pulse length through a small register port. It then writes a single command bit to start one of four operations: a normal read sense, a read sense that margins toward 0, a read sense that margins toward 1, or the programming of one fuse bit. The controller drives the bank's sense, margin and program strobes, and times the program pulse in periods of a slow reference. That reference reaches the block as a one-cycle enable tick. When the operation ends, the controller raises a one-cycle done pulse.

A sense operation lasts a fixed number of system clocks. On its closing edge, the word presented by the bank is stored in a readable data register. A write that sets more than one command bit starts nothing. It sets a sticky error flag instead, and software clears that flag by writing a 1 to it. While an operation is in flight, the block reports busy and ignores all writes.

Top module: `fuse_op_ctrl`

## Requirements
- R1: After reset, every strobe, `op_done`, the busy bit, the error bit, the length field, the location register and the data register are all 0.
- R2: Writing the control register (`reg_addr`=0) while idle with exactly one command bit set, either bit0 (normal sense), bit1 (0-margin sense) or bit2 (1-margin sense), holds `fuse_sense` high for exactly 4 clocks, starting in the cycle after the write.
- R3: `fuse_rs0` is high during every cycle of a 0-margin sense and `fuse_rs1` is high during every cycle of a 1-margin sense. Neither is high at any other time.
- R4: On the clock edge that ends a sense, the `fuse_rdata` value is stored in the data register (`reg_addr`=2). `op_done` is high for exactly the one following cycle.
- R5: A write that sets only bit3 (program) with a nonzero length L in bits [6:4] starts a program operation. `fuse_prog` then goes high in the next cycle and stays high up to and including the edge at which the L-th `tick_32k` is sampled. `op_done` pulses in the cycle after that edge.
- R6: A program command with L=0 never raises `fuse_prog` and pulses `op_done` in the cycle after the write.
- R7: Control bits [3:0] always read back as 0.
- R8: Control bit 8 (busy) reads 1 from the cycle after an operation starts until the cycle in which `op_done` is high, when it reads 0. Bits [6:4] read back the last accepted length.
- R9: While busy, every write to the control or location register is ignored.
- R10: An idle control write with two or more command bits sets control bit 9 (error) and starts no operation.
- R11: The error bit stays set until an idle control write that sets no command bits, or at most one, carries a 1 in bit 9.
- R12: The location register (`reg_addr`=1) holds a bit index in [4:0] and a word address in [15:8]. It drives `fuse_bit` and `fuse_addr` and reads back in the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle enable, once per slow reference period |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 location, 2 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| fuse_addr | output | 8 | Word address to the fuse bank |
| fuse_bit | output | 5 | Bit index for programming |
| fuse_sense | output | 1 | Sense strobe |
| fuse_rs0 | output | 1 | 0-margin sense strobe |
| fuse_rs1 | output | 1 | 1-margin sense strobe |
| fuse_prog | output | 1 | Program pulse |
| fuse_rdata | input | 32 | Word sensed by the bank |
| op_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `tick_32k` is a single-cycle pulse and that software never combines a multi-command write with an error clear. Under those assumptions, the sense and program strobes are never high together, and every falling edge of a strobe lines up with `op_done`. The stimulus raises a tick on a fixed stride of seven clocks. It drives a different `fuse_rdata` word each cycle, so the check catches a capture taken on the wrong edge. Every control write in the stimulus keeps the command bits and the clear bit apart. A per-cycle behavioural model then predicts every output, including the data read back, on each clock.

// File: rtl/fuse_op_ctrl.sv
module fuse_op_ctrl #(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int LW        = 3,
  parameter int SENSE_CYC = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_32k,
  input  logic                   reg_we,
  input  logic [1:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic [AW-1:0]          fuse_addr,
  output logic [$clog2(DW)-1:0]  fuse_bit,
  output logic                   fuse_sense,
  output logic                   fuse_rs0,
  output logic                   fuse_rs1,
  output logic                   fuse_prog,
  input  logic [DW-1:0]          fuse_rdata,
  output logic                   op_done
);
  localparam int BW   = $clog2(DW);
  localparam int SCW  = $clog2(SENSE_CYC);
  localparam int CNTW = (LW > SCW) ? LW : SCW;

  typedef enum logic [1:0] {K_NORM, K_M0, K_M1, K_PROG} kind_t;

  logic            busy, err, done_q;
  kind_t           kind;
  logic [CNTW-1:0] cnt;
  logic [LW-1:0]   len;
  logic [AW-1:0]   addr_q;
  logic [BW-1:0]   bit_q;
  logic [DW-1:0]   data_q;

  wire        ctrl_wr = reg_we && !busy && reg_addr == 2'd0;
  wire        loc_wr  = reg_we && !busy && reg_addr == 2'd1;
  wire [3:0]  cmd     = reg_wdata[3:0];
  wire        multi   = (cmd & (cmd - 4'd1)) != 4'd0;
  wire [LW-1:0] new_len = reg_wdata[4 +: LW];

  wire end_sense = busy && kind != K_PROG && cnt == '0;
  wire end_prog  = busy && kind == K_PROG && tick_32k && cnt == CNTW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      err    <= 1'b0;
      done_q <= 1'b0;
      kind   <= K_NORM;
      cnt    <= '0;
      len    <= '0;
      addr_q <= '0;
      bit_q  <= '0;
      data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy) begin
        if (end_sense) begin
          data_q <= fuse_rdata;
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else if (end_prog) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else if (kind != K_PROG || tick_32k) begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        if (loc_wr) begin
          addr_q <= reg_wdata[8 +: AW];
          bit_q  <= reg_wdata[0 +: BW];
        end
        if (ctrl_wr) begin
          len <= new_len;
          if (multi)             err <= 1'b1;
          else if (reg_wdata[9]) err <= 1'b0;
          if (!multi && cmd != 4'd0) begin
            if (cmd[3]) begin
              if (new_len == '0) done_q <= 1'b1;
              else begin
                busy <= 1'b1;
                kind <= K_PROG;
                cnt  <= CNTW'(new_len);
              end
            end else begin
              busy <= 1'b1;
              cnt  <= CNTW'(SENSE_CYC - 1);
              kind <= cmd[1] ? K_M0 : (cmd[2] ? K_M1 : K_NORM);
            end
          end
        end
      end
    end
  end

  assign fuse_sense = busy && kind != K_PROG;
  assign fuse_rs0   = busy && kind == K_M0;
  assign fuse_rs1   = busy && kind == K_M1;
  assign fuse_prog  = busy && kind == K_PROG;
  assign fuse_addr  = addr_q;
  assign fuse_bit   = bit_q;
  assign op_done    = done_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[4 +: LW] = len;
        reg_rdata[8]       = busy;
        reg_rdata[9]       = err;
      end
      2'd1: begin
        reg_rdata[8 +: AW] = addr_q;
        reg_rdata[0 +: BW] = bit_q;
      end
      2'd2: reg_rdata[DW-1:0] = data_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fuse_op_ctrl_chk.sv
module fuse_op_ctrl_chk #(
  parameter int AW = 8,
  parameter int BW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    reg_addr,
  input logic [31:0]   reg_rdata,
  input logic [AW-1:0] fuse_addr,
  input logic [BW-1:0] fuse_bit,
  input logic          fuse_sense,
  input logic          fuse_rs0,
  input logic          fuse_rs1,
  input logic          fuse_prog,
  input logic          op_done
);
  AST_MARGIN_NEEDS_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_rs0 || fuse_rs1) |-> fuse_sense); // R3
  AST_MARGIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fuse_rs0 && fuse_rs1)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fuse_sense && fuse_prog)); // R5
  AST_SENSE_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fuse_sense) |-> op_done); // R4
  AST_PROG_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fuse_prog) |-> op_done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> !fuse_sense && !fuse_prog); // R8
  AST_LOC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((fuse_sense || fuse_prog) && $past(fuse_sense || fuse_prog)) |-> ($stable(fuse_addr) && $stable(fuse_bit))); // R9
  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> reg_rdata[3:0] == 4'd0); // R7
endmodule

bind fuse_op_ctrl fuse_op_ctrl_chk #(.AW(AW), .BW($clog2(DW))) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .fuse_addr(fuse_addr), .fuse_bit(fuse_bit), .fuse_sense(fuse_sense),
  .fuse_rs0(fuse_rs0), .fuse_rs1(fuse_rs1), .fuse_prog(fuse_prog),
  .op_done(op_done)
);

// File: tb/fuse_op_ctrl_tb_top.sv
module fuse_op_ctrl_tb_top;
  logic clk = 0, rst_n = 0, tick_32k = 0, reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, fuse_rdata = 0;
  logic [7:0]  fuse_addr;
  logic [4:0]  fuse_bit;
  logic fuse_sense, fuse_rs0, fuse_rs1, fuse_prog, op_done;

  int checks = 0, failures = 0, cyc = 0;
  int m_busy = 0, m_kind = 0, m_cnt = 0, m_len = 0, m_err = 0, m_addr = 0, m_bit = 0, m_done = 0;
  int unsigned m_data = 0;
  int prog_seen = 0, done_seen = 0;

  always #2.5 clk = ~clk;

  fuse_op_ctrl dut_i (.clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fuse_addr(fuse_addr), .fuse_bit(fuse_bit), .fuse_sense(fuse_sense),
    .fuse_rs0(fuse_rs0), .fuse_rs1(fuse_rs1), .fuse_prog(fuse_prog),
    .fuse_rdata(fuse_rdata), .op_done(op_done));

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int unsigned exp_rdata(int a);
    case (a)
      0: return (m_len << 4) | (m_busy << 8) | (m_err << 9);
      1: return (m_addr << 8) | m_bit;
      2: return m_data;
      default: return 0;
    endcase
  endfunction

  task automatic model_edge();
    int c, n;
    m_done = 0;
    if (m_busy != 0) begin
      if (m_kind < 3) begin
        if (m_cnt == 0) begin m_data = fuse_rdata; m_busy = 0; m_done = 1; end
        else m_cnt--;
      end else if (tick_32k) begin
        if (m_cnt == 1) begin m_busy = 0; m_done = 1; end
        else m_cnt--;
      end
    end else if (reg_we) begin
      if (reg_addr == 1) begin m_addr = (reg_wdata >> 8) & 8'hFF; m_bit = reg_wdata & 5'h1F; end
      if (reg_addr == 0) begin
        c = reg_wdata & 4'hF;
        n = $countones(reg_wdata[3:0]);
        m_len = (reg_wdata >> 4) & 7;
        if (reg_wdata[9]) m_err = 0;
        if (n > 1) m_err = 1;
        else if (n == 1) begin
          if (c == 8) begin
            if (m_len == 0) m_done = 1;
            else begin m_busy = 1; m_kind = 3; m_cnt = m_len; end
          end else begin
            m_busy = 1; m_cnt = 3;
            m_kind = (c == 1) ? 0 : (c == 2) ? 1 : 2;
          end
        end
      end
    end
  endtask

  task automatic step(logic we = 0, logic [1:0] a = 0, logic [31:0] d = 0);
    reg_we = we; reg_addr = a; reg_wdata = d;
    tick_32k = (cyc % 7 == 6);
    fuse_rdata = 32'h9E37_79B9 * (cyc + 3);
    model_edge();
    @(posedge clk); @(negedge clk);
    cyc++;
    check("R2 fuse_sense", fuse_sense, (m_busy != 0 && m_kind < 3));
    check("R3 fuse_rs0", fuse_rs0, (m_busy != 0 && m_kind == 1));
    check("R3 fuse_rs1", fuse_rs1, (m_busy != 0 && m_kind == 2));
    check("R5 fuse_prog", fuse_prog, (m_busy != 0 && m_kind == 3));
    check("R4 op_done", op_done, m_done);
    check("R12 fuse_addr", {fuse_addr, 3'b0, fuse_bit}, (m_addr << 8) | m_bit);
    check("R8 reg_rdata", reg_rdata, exp_rdata(a));
    if (fuse_prog) prog_seen++;
    if (op_done) done_seen++;
  endtask

  task automatic idle(int n, logic [1:0] a = 0);
    for (int i = 0; i < n; i++) step(0, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset strobes", {fuse_sense, fuse_rs0, fuse_rs1, fuse_prog, op_done}, 0);
    check("R1 reset ctrl", reg_rdata, 0);
    rst_n = 1;
    idle(2);
    step(1, 1, 32'h0000_A511);
    idle(1, 1);
    check("R12 location readback", reg_rdata, 32'h0000_A511);
    check("R12 fuse_addr/bit", {fuse_addr, fuse_bit}, {8'hA5, 5'd17});
    step(1, 0, 32'h1);
    idle(1, 0);
    check("R8 busy while sensing", reg_rdata[8], 1);
    check("R7 command bits read zero", reg_rdata[3:0], 0);
    idle(5, 2);
    check("R4 data captured", reg_rdata, m_data);
    step(1, 0, 32'h2); idle(6, 2);
    step(1, 0, 32'h4); idle(6, 2);
    prog_seen = 0; done_seen = 0;
    step(1, 0, 32'h38);
    idle(3);
    step(1, 0, 32'h1);
    step(1, 1, 32'h0000_3C02);
    idle(28, 1);
    check("R9 location unchanged by busy write", reg_rdata, 32'h0000_A511);
    check("R5 program pulse length", prog_seen, 3 * 7 >= prog_seen ? prog_seen : 0);
    check("R5 one done", done_seen, 1);
    check("R9 no sense after busy write", fuse_sense, 0);
    prog_seen = 0; done_seen = 0;
    step(1, 0, 32'h8);
    check("R6 done next cycle", op_done, 1);
    idle(3);
    check("R6 no program pulse", prog_seen, 0);
    step(1, 0, 32'h5);
    check("R10 no sense on multi", fuse_sense, 0);
    check("R10 error set", reg_rdata[9], 1);
    idle(4);
    check("R11 error sticky", reg_rdata[9], 1);
    step(1, 0, 32'h200);
    check("R11 error cleared", reg_rdata[9], 0);
    step(1, 0, 32'h18); idle(12);
    step(1, 0, 32'hC); idle(3);
    check("R10 error on prog+sense", reg_rdata[9], 1);
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule